// File: doc/BRIEF.md
# Translation Miss Fault Capture

This block captures processor state when an address translation lookup misses on a load or a store, and it produces the address of the miss handler. A miss arrives as a single-cycle strobe together with the faulting virtual address, the program counter of the faulting instruction, a load/store selector and the current processor status word. On the next clock edge the block loads its fault-address, page-context, translation-tag, reason and return-address registers. It also presents the status word with the exception-level flag set, plus the handler address, and pulses a done signal.

The page-context and translation-tag registers are merges. The miss replaces only the virtual page number fields and leaves the page-table base bits and the address-space tag bits as they were. Those preserved bits are loaded beforehand through two plain write ports. The lookup itself and any table walk belong to neighbouring logic.

Top module: `xfc_capture`

## Requirements
- R1: After reset, done_o is 0 and handler_pc_o, fault_addr_o, ctx_o, hi_o, cause_o, epc_o and status_o are all zero.
- R2: On a miss strobe, fault_addr_o takes the full 32-bit faulting address.
- R3: On a miss, ctx_o becomes its previous bits [31:23] and [3:0] with bits [22:4] replaced by faulting address bits [31:13].
- R4: On a miss, hi_o becomes faulting address bits [31:13] in bits [31:13], with its previous bits [12:0] kept.
- R5: On a miss, cause_o is written whole: reason code 2 in bits [6:2] for a load (is_store_i = 0), code 3 for a store (is_store_i = 1), all other bits zero.
- R6: On a miss with status_i bit 1 clear, epc_o becomes pc_i − 4. With status_i bit 1 set, epc_o keeps its value.
- R7: On a miss, handler_pc_o becomes 0x80000000 when status_i bit 0 is clear and 0x80000180 when it is set.
- R8: On a miss, status_o becomes status_i with bit 1 set, whatever its previous value.
- R9: done_o is high for exactly the one cycle after each miss strobe. Without a strobe, no captured register changes except through R10.
- R10: When ctx_we_i or hi_we_i is high without a miss, ctx_o or hi_o loads the write data on the next edge. When a miss arrives in the same cycle, the write is ignored and the merge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | Translation miss strobe |
| is_store_i | input | 1 | 1 = store miss, 0 = load miss |
| vaddr_i | input | 32 | Faulting virtual address |
| pc_i | input | 32 | Program counter of the faulting access |
| status_i | input | 32 | Current status word (bit 0 vector select, bit 1 exception level) |
| ctx_we_i | input | 1 | Page-context write enable |
| ctx_wdata_i | input | 32 | Page-context write data |
| hi_we_i | input | 1 | Translation-tag write enable |
| hi_wdata_i | input | 32 | Translation-tag write data |
| done_o | output | 1 | One-cycle pulse after a capture |
| handler_pc_o | output | 32 | Handler address to fetch from |
| fault_addr_o | output | 32 | Captured faulting address |
| ctx_o | output | 32 | Page-context register |
| hi_o | output | 32 | Translation-tag register |
| cause_o | output | 32 | Fault reason register |
| epc_o | output | 32 | Return address register |
| status_o | output | 32 | Status word with exception level set |

## Verification
The bench preloads the context and tag registers with all-ones and alternating patterns, so that a merge which clears or takes the wrong preserved bits shows at once. A misplaced shift would put the page number off by one nibble, and the expected values catch that. Misses are raised with the exception-level flag already set to confirm that the return address is not overwritten; a design that always wrote it would lose the original return point in a nested fault. The bench drives a miss in the same cycle as a register write to check that the merge wins. It crosses both vector selections with both access kinds, which exposes a swapped reason code or a wrong handler offset.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int unsigned XW = 32;

    typedef enum logic [4:0] {
        XC_LOAD_MISS  = 5'd2,
        XC_STORE_MISS = 5'd3
    } xcode_e;

    typedef struct packed {
        logic          done;
        logic [XW-1:0] handler;
        logic [XW-1:0] fault_addr;
        logic [XW-1:0] ctx;
        logic [XW-1:0] hi;
        logic [XW-1:0] cause;
        logic [XW-1:0] epc;
        logic [XW-1:0] status;
    } xfc_state_t;
endpackage

// File: rtl/xfc_field_merge.sv
module xfc_field_merge #(
    parameter int unsigned XW        = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned CTX_LOW   = 4
) (
    input  logic [XW-1:0] vaddr_i,
    input  logic [XW-1:0] ctx_old_i,
    input  logic [XW-1:0] hi_old_i,
    output logic [XW-1:0] ctx_new_o,
    output logic [XW-1:0] hi_new_o
);
    localparam int unsigned VPN_W   = XW - PAGE_BITS;
    localparam int unsigned CTX_TOP = XW - VPN_W - CTX_LOW;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn       = vaddr_i[XW-1:PAGE_BITS];
        hi_new_o  = {vpn, hi_old_i[PAGE_BITS-1:0]};
        ctx_new_o = ctx_old_i;
        ctx_new_o[CTX_LOW +: VPN_W] = vpn;
    end

    initial begin
        if (CTX_TOP + VPN_W + CTX_LOW != XW)
            $error("xfc_field_merge: field widths do not add up");
    end
endmodule

// File: rtl/xfc_vector_sel.sv
module xfc_vector_sel
    import xfc_pkg::*;
#(
    parameter int unsigned    W        = 32,
    parameter logic [W-1:0]   VEC_BASE = 32'h8000_0000,
    parameter logic [W-1:0]   VEC_ALT  = 32'h0000_0180,
    parameter int unsigned    CODE_LSB = 2
) (
    input  logic         is_store_i,
    input  logic         alt_vec_i,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] handler_o,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] ret_pc_o
);
    localparam logic [W-1:0] INSN_BYTES = W'(4);

    xcode_e code;

    always_comb begin
        code      = is_store_i ? XC_STORE_MISS : XC_LOAD_MISS;
        cause_o   = '0;
        cause_o[CODE_LSB +: 5] = code;
        handler_o = alt_vec_i ? (VEC_BASE + VEC_ALT) : VEC_BASE;
        ret_pc_o  = pc_i - INSN_BYTES;
    end
endmodule

// File: rtl/xfc_capture.sv
module xfc_capture
    import xfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_i,
    input  logic          is_store_i,
    input  logic [XW-1:0] vaddr_i,
    input  logic [XW-1:0] pc_i,
    input  logic [XW-1:0] status_i,
    input  logic          ctx_we_i,
    input  logic [XW-1:0] ctx_wdata_i,
    input  logic          hi_we_i,
    input  logic [XW-1:0] hi_wdata_i,
    output logic          done_o,
    output logic [XW-1:0] handler_pc_o,
    output logic [XW-1:0] fault_addr_o,
    output logic [XW-1:0] ctx_o,
    output logic [XW-1:0] hi_o,
    output logic [XW-1:0] cause_o,
    output logic [XW-1:0] epc_o,
    output logic [XW-1:0] status_o
);
    localparam int unsigned ST_VEC = 0;
    localparam int unsigned ST_EXL = 1;

    xfc_state_t st_d, st_q;

    logic [XW-1:0] ctx_merged, hi_merged;
    logic [XW-1:0] handler_sel, cause_sel, ret_pc_sel;

    xfc_field_merge #(.XW(XW), .PAGE_BITS(13), .CTX_LOW(4)) u_merge (
        .vaddr_i   (vaddr_i),
        .ctx_old_i (st_q.ctx),
        .hi_old_i  (st_q.hi),
        .ctx_new_o (ctx_merged),
        .hi_new_o  (hi_merged)
    );

    xfc_vector_sel #(.W(XW)) u_vec (
        .is_store_i (is_store_i),
        .alt_vec_i  (status_i[ST_VEC]),
        .pc_i       (pc_i),
        .handler_o  (handler_sel),
        .cause_o    (cause_sel),
        .ret_pc_o   (ret_pc_sel)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = miss_i;
        if (miss_i) begin
            st_d.fault_addr = vaddr_i;
            st_d.ctx        = ctx_merged;
            st_d.hi         = hi_merged;
            st_d.cause      = cause_sel;
            st_d.handler    = handler_sel;
            st_d.status     = status_i | (XW'(1) << ST_EXL);
            if (!status_i[ST_EXL])
                st_d.epc = ret_pc_sel;
        end else begin
            if (ctx_we_i) st_d.ctx = ctx_wdata_i;
            if (hi_we_i)  st_d.hi  = hi_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o       = st_q.done;
    assign handler_pc_o = st_q.handler;
    assign fault_addr_o = st_q.fault_addr;
    assign ctx_o        = st_q.ctx;
    assign hi_o         = st_q.hi;
    assign cause_o      = st_q.cause;
    assign epc_o        = st_q.epc;
    assign status_o     = st_q.status;

    p_addr_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> fault_addr_o == $past(vaddr_i));

    p_ctx_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> (ctx_o[31:23] == $past(ctx_o[31:23])) && (ctx_o[3:0] == $past(ctx_o[3:0])));

    p_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> hi_o[12:0] == $past(hi_o[12:0]));

    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cause_o[6:2] == 5'd2 || cause_o[6:2] == 5'd3) && $countones(cause_o[1:0]) == 0);

    p_epc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && status_i[1]) |=> $stable(epc_o));

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (handler_pc_o == 32'h8000_0000 || handler_pc_o == 32'h8000_0180));

    p_exl_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> status_o[1]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> done_o);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_i |=> !done_o && $stable(fault_addr_o) && $stable(cause_o) && $stable(epc_o));

    p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_we_i && !miss_i) |=> ctx_o == $past(ctx_wdata_i));
endmodule

// File: tb/xfc_capture_test.sv
module xfc_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_i = 1'b0, is_store_i = 1'b0;
    logic [31:0] vaddr_i = '0, pc_i = '0, status_i = '0;
    logic        ctx_we_i = 1'b0, hi_we_i = 1'b0;
    logic [31:0] ctx_wdata_i = '0, hi_wdata_i = '0;
    logic        done_o;
    logic [31:0] handler_pc_o, fault_addr_o, ctx_o, hi_o, cause_o, epc_o, status_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xfc_capture uut (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .is_store_i(is_store_i),
        .vaddr_i(vaddr_i), .pc_i(pc_i), .status_i(status_i),
        .ctx_we_i(ctx_we_i), .ctx_wdata_i(ctx_wdata_i),
        .hi_we_i(hi_we_i), .hi_wdata_i(hi_wdata_i),
        .done_o(done_o), .handler_pc_o(handler_pc_o), .fault_addr_o(fault_addr_o),
        .ctx_o(ctx_o), .hi_o(hi_o), .cause_o(cause_o), .epc_o(epc_o), .status_o(status_o)
    );

    // entry: {store, status[1:0], vaddr, pc, ctx preload, hi preload}
    localparam int NV = 6;
    localparam logic [130:0] VEC [NV] = '{
        {1'b0, 2'b00, 32'h1234_5678, 32'h0040_0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 2'b01, 32'hDEAD_BEEF, 32'h0040_0200, 32'hAAAA_AAAA, 32'h5555_5555},
        {1'b0, 2'b10, 32'h0000_2000, 32'h0040_0300, 32'h0000_0000, 32'h0000_1FFF},
        {1'b1, 2'b11, 32'hFFFF_FFFF, 32'h0040_0400, 32'h1357_9BDF, 32'h0000_0000},
        {1'b1, 2'b00, 32'h8000_1FFF, 32'h0000_0000, 32'hFF80_000F, 32'hFFFF_E000},
        {1'b0, 2'b01, 32'h7FFF_E000, 32'hBFC0_0004, 32'h007F_FFF0, 32'h0000_0ABC}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctx(input logic [31:0] old, input logic [31:0] va);
        return (old & 32'hFF80_000F) | ((va >> 9) & 32'h007F_FFF0);
    endfunction

    function automatic logic [31:0] exp_hi(input logic [31:0] old, input logic [31:0] va);
        return (va & 32'hFFFF_E000) | (old & 32'h0000_1FFF);
    endfunction

    task automatic do_miss(input logic st, input logic [31:0] stat,
                           input logic [31:0] va, input logic [31:0] pc);
        @(negedge clk);
        miss_i = 1'b1; is_store_i = st; status_i = stat; vaddr_i = va; pc_i = pc;
        @(negedge clk);
        miss_i = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp_epc;
        logic [31:0] old_ctx, old_hi;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", {31'b0, done_o}, 32'h0);
        chk("R1 handler", handler_pc_o, 32'h0);
        chk("R1 fault_addr", fault_addr_o, 32'h0);
        chk("R1 ctx", ctx_o, 32'h0);
        chk("R1 hi", hi_o, 32'h0);
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 status", status_o, 32'h0);
        rst_n = 1'b1;
        exp_epc = 32'h0;

        for (int i = 0; i < NV; i++) begin
            logic        st;
            logic [1:0]  sb;
            logic [31:0] va, pc, cp, hp, stat;
            {st, sb, va, pc, cp, hp} = VEC[i];
            stat = {28'hA5A5_A5A, 2'b00, sb};
            // R10 preload through write ports
            @(negedge clk);
            ctx_we_i = 1'b1; ctx_wdata_i = cp; hi_we_i = 1'b1; hi_wdata_i = hp;
            @(negedge clk);
            ctx_we_i = 1'b0; hi_we_i = 1'b0;
            chk("R10 ctx write", ctx_o, cp);
            chk("R10 hi write", hi_o, hp);
            @(negedge clk);
            miss_i = 1'b1; is_store_i = st; status_i = stat; vaddr_i = va; pc_i = pc;
            @(negedge clk);
            miss_i = 1'b0;
            if (!sb[1]) exp_epc = pc - 32'd4;
            chk("R9 done", {31'b0, done_o}, 32'h1);
            chk("R2 fault_addr", fault_addr_o, va);
            chk("R3 ctx merge", ctx_o, exp_ctx(cp, va));
            chk("R4 hi merge", hi_o, exp_hi(hp, va));
            chk("R5 cause", cause_o, st ? 32'h0000_000C : 32'h0000_0008);
            chk("R6 epc", epc_o, exp_epc);
            chk("R7 handler", handler_pc_o, sb[0] ? 32'h8000_0180 : 32'h8000_0000);
            chk("R8 status", status_o, stat | 32'h2);
            @(negedge clk);
            chk("R9 done drops", {31'b0, done_o}, 32'h0);
            chk("R9 idle hold", fault_addr_o, va);
        end

        // R6: nested miss with EXL set keeps epc even with a new pc
        do_miss(1'b0, 32'h0000_0000, 32'h1000_0000, 32'h0000_1000);
        chk("R6 epc written", epc_o, 32'h0000_0FFC);
        do_miss(1'b1, 32'h0000_0002, 32'h2000_0000, 32'h0000_5000);
        chk("R6 epc kept", epc_o, 32'h0000_0FFC);
        chk("R8 status already set", status_o, 32'h0000_0002);

        // R10: miss wins over same-cycle writes
        @(negedge clk);
        ctx_we_i = 1'b1; ctx_wdata_i = 32'hFFFF_FFFF; hi_we_i = 1'b1; hi_wdata_i = 32'h0000_0123;
        @(negedge clk);
        ctx_we_i = 1'b0; hi_we_i = 1'b0;
        old_ctx = ctx_o; old_hi = hi_o;
        @(negedge clk);
        miss_i = 1'b1; is_store_i = 1'b0; status_i = 32'h1; vaddr_i = 32'h0246_8000; pc_i = 32'h100;
        ctx_we_i = 1'b1; ctx_wdata_i = 32'h1111_1111; hi_we_i = 1'b1; hi_wdata_i = 32'h2222_2222;
        @(negedge clk);
        miss_i = 1'b0; ctx_we_i = 1'b0; hi_we_i = 1'b0;
        chk("R10 ctx miss priority", ctx_o, exp_ctx(old_ctx, 32'h0246_8000));
        chk("R10 hi miss priority", hi_o, exp_hi(old_hi, 32'h0246_8000));

        // R9: no strobe, changing inputs leave outputs alone
        @(negedge clk);
        vaddr_i = 32'hCAFE_F00D; pc_i = 32'h4444; status_i = 32'h0; is_store_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 hold addr", fault_addr_o, 32'h0246_8000);
        chk("R9 hold cause", cause_o, 32'h0000_0008);
        chk("R9 hold handler", handler_pc_o, 32'h8000_0180);

        // R1 again after mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset ctx", ctx_o, 32'h0);
        chk("R1 reset epc", epc_o, 32'h0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule